// File: doc/BRIEF.md
# Rotor Lock Detector with Speed Outputs

This block watches the three filtered Hall sensor bits of a three-phase brushless motor. It produces two speed-feedback toggle signals and guards against a stalled rotor. The first speed output changes level on every move between valid Hall codes. The second changes level only when the A sensor bit changes. A controller can time either one to measure rotor speed.

The lock monitor counts ticks of a slow timing reference. A tick is a single-cycle strobe that stands in for one period of the external timing oscillator. Progress means a step to the next position of the six-step commutation order for the selected direction. Each such step restarts the count. When the count reaches the lock limit with no progress, a lock fault is latched, and the fault is the signal that shuts off the power stage. A rotor rocking between two adjacent Hall states does not count as progress, so it also ends in a fault. The fault is released only by a direction change, a power-up undervoltage reset, a long drive-off period on the enable input, or the disable strap. Brake mode freezes the count and masks the flag.

Top module: `rotor_lock_monitor`

## Requirements
- R1: `fg1_o` changes level exactly once each time `hall_i` moves from one valid code to a different valid code. Codes 000 and 111 are invalid: entering or leaving them causes no change. The first valid code after reset is captured without a toggle. `fg1_o` is 0 after reset.
- R2: `fg2_o` changes level exactly once each time a move between valid codes changes `hall_i[2]` (sensor A). It is 0 after reset.
- R3: With `hall_i` = {A,B,C}, the forward order (`dir_i`=1) is 101, 100, 110, 010, 011, 001, then back to 101. `dir_i`=0 walks the same list backwards. A step to the next code in the selected order restarts the lock count from zero. A step against the order does not restart it.
- R4: With no progress, the fault sets on the clock edge of the 127th counted tick (`LOCK_TICKS`) and is visible on `lock_fault_o` after that edge. After 126 ticks it is still 0.
- R5: Repeated hopping between two adjacent Hall codes restarts the count at most once, and therefore leads to a fault.
- R6: Once set, the fault stays set under further ticks and Hall progress. Either edge of `dir_i` clears it on the next clock edge.
- R7: A high `uvlo_i` clears the fault and the lock count on the next clock edge.
- R8: `pwm_off_i` high means the drive is chopped off. If it stays high for 64 counted ticks (`CLEAR_TICKS`), the fault clears one edge after the 64th tick. A low level restarts that count, so shorter high periods never clear the fault.
- R9: While `brake_ni` is 0, the lock count is held at zero and `lock_fault_o` reads 0. A latched fault reappears when the brake is released.
- R10: While `lock_off_i` is 1, no fault can set and any latched fault is cleared. The count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| hall_i | input | 3 | filtered Hall bits {A,B,C} |
| dir_i | input | 1 | 1 forward, 0 reverse |
| brake_ni | input | 1 | active-low brake request |
| pwm_off_i | input | 1 | 1 while drive is chopped off |
| uvlo_i | input | 1 | power-up / undervoltage reset of the lock logic |
| lock_off_i | input | 1 | strap that disables lock detection |
| tick_i | input | 1 | one-cycle strobe per timing oscillator period |
| fg1_o | output | 1 | toggles on every valid Hall change |
| fg2_o | output | 1 | toggles on every change of sensor A |
| lock_fault_o | output | 1 | latched lock fault, masked during brake |

## Verification
The assertions assume that `hall_i` is already filtered and synchronous to `clk_i`. They also assume that `tick_i` is a strobe of one cycle, and that `dir_i` is synchronous so that each level change is a single edge. The bench changes every input only on the falling clock edge, and it holds each Hall code for whole cycles. It drives ticks only while the Hall bits are steady, so each Hall step and each tick can be counted apart. This lets the bench compute the exact edge on which the lock count expires.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  localparam logic [2:0] IDX_NONE = 3'd7;

  // position in the six-step order, IDX_NONE for invalid codes
  function automatic logic [2:0] hall_idx(input logic [2:0] h);
    case (h)
      3'b101:  hall_idx = 3'd0;
      3'b100:  hall_idx = 3'd1;
      3'b110:  hall_idx = 3'd2;
      3'b010:  hall_idx = 3'd3;
      3'b011:  hall_idx = 3'd4;
      3'b001:  hall_idx = 3'd5;
      default: hall_idx = IDX_NONE;
    endcase
  endfunction

  function automatic logic [2:0] next_idx(input logic [2:0] idx, input logic fwd);
    if (fwd) next_idx = (idx == 3'd5) ? 3'd0 : idx + 3'd1;
    else     next_idx = (idx == 3'd0) ? 3'd5 : idx - 3'd1;
  endfunction
endpackage

// File: rtl/rlm_hall_tracker.sv
module rlm_hall_tracker
  import rlm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  output logic       fg1_o,
  output logic       fg2_o,
  output logic       progress_o
);
  logic [2:0] last_q, anchor_q, idx;
  logic       seeded_q, fg1_q, fg2_q, valid, moved;

  assign idx        = hall_idx(hall_i);
  assign valid      = (idx != IDX_NONE);
  assign moved      = seeded_q && valid && (hall_i != last_q);
  assign progress_o = moved && (idx == next_idx(anchor_q, dir_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q   <= 3'b000;
      anchor_q <= 3'd0;
      seeded_q <= 1'b0;
      fg1_q    <= 1'b0;
      fg2_q    <= 1'b0;
    end else if (valid && !seeded_q) begin
      seeded_q <= 1'b1;
      last_q   <= hall_i;
      anchor_q <= idx;
    end else if (moved) begin
      last_q <= hall_i;
      fg1_q  <= ~fg1_q;
      if (hall_i[2] != last_q[2]) fg2_q <= ~fg2_q;
      if (progress_o) anchor_q <= idx;
    end
  end

  assign fg1_o = fg1_q;
  assign fg2_o = fg2_q;

  // R1: invalid codes never toggle the speed output
  p_invalid_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hall_i == 3'b000 || hall_i == 3'b111) |=> $stable(fg1_q));
  // R2: every A-sensor toggle is also a Hall change
  p_fg2_implies_fg1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fg2_q) |-> !$stable(fg1_q));
endmodule

// File: rtl/rlm_clear_timer.sv
module rlm_clear_timer #(
  parameter int unsigned CLEAR_TICKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_off_i,
  input  logic tick_i,
  output logic clr_o
);
  localparam int unsigned CW = $clog2(CLEAR_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CLEAR_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!pwm_off_i)             cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign clr_o = (cnt_q == LIMIT);

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  p_low_restarts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_off_i |=> cnt_q == '0);
endmodule

// File: rtl/rlm_lock_timer.sv
module rlm_lock_timer #(
  parameter int unsigned LOCK_TICKS = 127
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic progress_i,
  input  logic dir_i,
  input  logic brake_ni,
  input  logic uvlo_i,
  input  logic lock_off_i,
  input  logic clr_en_i,
  output logic fault_o
);
  localparam int unsigned CW = $clog2(LOCK_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          fault_q, dir_q, clear;

  assign clear = (dir_i != dir_q) || uvlo_i || clr_en_i || lock_off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      dir_q <= dir_i;
      if (clear) begin
        cnt_q   <= '0;
        fault_q <= 1'b0;
      end else if (!brake_ni || fault_q || progress_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          fault_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign fault_o = fault_q;

  p_expiry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(cnt_q) == LAST);
  p_latched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && dir_i == dir_q && !uvlo_i && !clr_en_i && !lock_off_i) |=> fault_q);
  p_uvlo_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> !fault_q);
  p_brake_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brake_ni |=> cnt_q == '0);
  p_strap_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_off_i |=> !fault_q);
endmodule

// File: rtl/rotor_lock_monitor.sv
module rotor_lock_monitor #(
  parameter int unsigned LOCK_TICKS  = 127,
  parameter int unsigned CLEAR_TICKS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  input  logic       brake_ni,
  input  logic       pwm_off_i,
  input  logic       uvlo_i,
  input  logic       lock_off_i,
  input  logic       tick_i,
  output logic       fg1_o,
  output logic       fg2_o,
  output logic       lock_fault_o
);
  logic progress, clr_en, fault;

  rlm_hall_tracker u_track (
    .clk_i, .rst_ni, .hall_i, .dir_i,
    .fg1_o, .fg2_o, .progress_o(progress)
  );

  rlm_clear_timer #(.CLEAR_TICKS(CLEAR_TICKS)) u_clr (
    .clk_i, .rst_ni, .pwm_off_i, .tick_i, .clr_o(clr_en)
  );

  rlm_lock_timer #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk_i, .rst_ni, .tick_i, .progress_i(progress), .dir_i, .brake_ni,
    .uvlo_i, .lock_off_i, .clr_en_i(clr_en), .fault_o(fault)
  );

  // brake takes precedence over the lock fault
  assign lock_fault_o = fault && brake_ni;

  p_brake_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brake_ni |-> !lock_fault_o);
endmodule

// File: tb/rotor_lock_monitor_tb.sv
`timescale 1ns/1ps
module rotor_lock_monitor_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] hall_i = 3'b101;
  logic       dir_i = 1'b1, brake_ni = 1'b1, pwm_off_i = 1'b0;
  logic       uvlo_i = 1'b0, lock_off_i = 1'b0, tick_i = 1'b0;
  logic       fg1_o, fg2_o, lock_fault_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rotor_lock_monitor u_dut (.*);

  // {hall, fg1, fg2} after each step, starting from seed 101
  localparam logic [4:0] VEC [10] = '{
    {3'b100, 1'b1, 1'b0}, {3'b110, 1'b0, 1'b0}, {3'b000, 1'b0, 1'b0},
    {3'b110, 1'b0, 1'b0}, {3'b010, 1'b1, 1'b1}, {3'b011, 1'b0, 1'b1},
    {3'b111, 1'b0, 1'b1}, {3'b001, 1'b1, 1'b1}, {3'b101, 1'b0, 1'b0},
    {3'b100, 1'b1, 1'b0}
  };

  task automatic run(input int n, input bit tk);
    repeat (n) begin
      tick_i = tk;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset fg1", fg1_o, 1'b0);
    chk("R2 reset fg2", fg2_o, 1'b0);
    chk("R4 reset fault", lock_fault_o, 1'b0);
    rst_ni = 1'b1;
    run(2, 0);
    chk("R1 seed no toggle", fg1_o, 1'b0);

    for (int i = 0; i < 10; i++) begin
      hall_i = VEC[i][4:2];
      run(1, 0);
      chk("R1 fg1 vector", fg1_o, VEC[i][1]);
      chk("R2 fg2 vector", fg2_o, VEC[i][0]);
      chk("R3 forward no fault", lock_fault_o, 1'b0);
    end

    run(126, 1);
    chk("R4 before expiry", lock_fault_o, 1'b0);
    run(1, 1);
    chk("R4 at expiry", lock_fault_o, 1'b1);

    run(5, 1);
    chk("R6 latched ticks", lock_fault_o, 1'b1);
    hall_i = 3'b110; run(1, 0);
    chk("R6 latched progress", lock_fault_o, 1'b1);
    dir_i = 1'b0; run(1, 0);
    chk("R6 dir fall clear", lock_fault_o, 1'b0);
    dir_i = 1'b1; run(1, 0);
    chk("R6 dir rise", lock_fault_o, 1'b0);

    for (int i = 0; i < 130; i++) begin
      hall_i = (i % 2 == 0) ? 3'b100 : 3'b110;
      run(1, 1);
    end
    chk("R5 bounce faults", lock_fault_o, 1'b1);
    hall_i = 3'b110;
    dir_i = 1'b0; run(1, 0);
    chk("R6 clear to reverse", lock_fault_o, 1'b0);

    run(100, 1);
    hall_i = 3'b100; run(1, 0);
    run(100, 1);
    chk("R3 reverse restarts", lock_fault_o, 1'b0);
    hall_i = 3'b101; run(1, 0);
    run(100, 1);
    hall_i = 3'b100; run(1, 0);
    run(26, 1);
    chk("R3 wrong way no restart pre", lock_fault_o, 1'b0);
    run(1, 1);
    chk("R3 wrong way no restart", lock_fault_o, 1'b1);

    uvlo_i = 1'b1; run(1, 0); uvlo_i = 1'b0;
    chk("R7 uvlo clear", lock_fault_o, 1'b0);

    run(127, 1);
    chk("R4 refault", lock_fault_o, 1'b1);
    pwm_off_i = 1'b1; run(50, 1);
    pwm_off_i = 1'b0; run(1, 0);
    pwm_off_i = 1'b1; run(50, 1);
    chk("R8 split high no clear", lock_fault_o, 1'b1);
    pwm_off_i = 1'b0; run(1, 0);
    pwm_off_i = 1'b1; run(63, 1);
    chk("R8 63 ticks", lock_fault_o, 1'b1);
    run(1, 1);
    chk("R8 64th tick edge", lock_fault_o, 1'b1);
    run(1, 0);
    chk("R8 cleared", lock_fault_o, 1'b0);

    pwm_off_i = 1'b0; brake_ni = 1'b0;
    run(200, 1);
    chk("R9 brake holds count", lock_fault_o, 1'b0);
    brake_ni = 1'b1;
    run(126, 1);
    chk("R9 count restarted", lock_fault_o, 1'b0);
    run(1, 1);
    chk("R9 expiry after brake", lock_fault_o, 1'b1);
    brake_ni = 1'b0; run(1, 0);
    chk("R9 brake masks", lock_fault_o, 1'b0);
    brake_ni = 1'b1; run(1, 0);
    chk("R9 fault returns", lock_fault_o, 1'b1);

    lock_off_i = 1'b1; run(1, 0);
    chk("R10 strap clears", lock_fault_o, 1'b0);
    run(200, 1);
    chk("R10 strap no fault", lock_fault_o, 1'b0);
    lock_off_i = 1'b0;
    run(126, 1);
    chk("R10 count held", lock_fault_o, 1'b0);
    run(1, 1);
    chk("R10 detection back", lock_fault_o, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule